// File: doc/BRIEF.md
# Masked Sticky Event Status with Interrupt

This block watches three hardware event lines (clock error, overflow and underflow) and records each one in a sticky status register. The host reads that register over a simple single-cycle register port. Each source has its own enable bit and its own trigger mode. The trigger mode can be rising edge, falling edge or level. Reading the status register returns the recorded bits and clears them in the same access.

An interrupt output is active while any enabled status bit is set. A control bit selects how that output is driven:
- as an active-high push-pull driver, or
- as an active-low open-drain driver.

Open-drain drive is modelled by two pins: a value pin and an output-enable pin. A pad outside the block drives the value when the enable is high and releases the line to high impedance otherwise.

The register port is a plain strobe interface, not a stream. A read or a write is accepted in the cycle its strobe is high, so there is no back-pressure. Read data is combinational from the current address and state. Writes take effect at the clock edge that ends the access cycle.

Top module: `evt_status_irq`

## Requirements
- R1: After reset every register reads 00h, no status bit is set, and the interrupt is released (`irq_oe`=0, `irq_out`=0).
- R2: Register map and bit layout:
  - Address 0 is the status register, with clock error at bit 3, overflow at bit 1 and underflow at bit 0.
  - The enable mask (address 1), mode-high (address 2) and mode-low (address 3) registers use those same bit positions.
  - Address 4 bit 0 is the polarity bit.
  - All other bits, and all other addresses, read 0.
- R3: A status bit stays set until a status read, even after its event line has settled. An event line sampled at clock edge k can set its bit no earlier than the value visible after edge k+1.
- R4: A cycle with `reg_rd`=1 and address 0 returns the current bits on `reg_rdata`, and clears them at the end of that cycle.
- R5: A trigger that occurs in the same cycle as a status read leaves its bit set after that read.
- R6: A source whose enable bit is 0 never sets its status bit. Clearing an enable bit also clears and hides that source's status bit.
- R7: Mode 00 (mode-high bit 0, mode-low bit 0) sets the bit when the event line goes from 0 to 1.
- R8: Mode 01 sets the bit when the event line goes from 1 to 0.
- R9: Mode 10 sets the bit in every cycle that the sampled event line is 1, so the bit is set again after a read while the line stays high.
- R10: Mode 11 never sets the status bit.
- R11: With polarity 1, `irq_oe` is 1 and `irq_out` is 1 exactly when some enabled status bit is set.
- R12: With polarity 0, `irq_out` is 0 and `irq_oe` is 1 exactly when some enabled status bit is set.
- A configuration write takes effect at its clock edge. The trigger decision at that same edge still uses the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_err_evt | input | 1 | Clock error condition line |
| ovfl_evt | input | 1 | Overflow condition line |
| undfl_evt | input | 1 | Underflow condition line |
| reg_wr | input | 1 | Write strobe for `reg_addr` |
| reg_rd | input | 1 | Read strobe; at address 0 it clears the status bits |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_out | output | 1 | Interrupt drive value |
| irq_oe | output | 1 | Interrupt drive enable (0 = released) |

## Verification
A wrong edge register or mode decode shows up as a status bit that is set or missing at the exact cycle the bench predicts. That cycle is two edges after the event line changes. A broken clear-on-read shows up as stale bits on the next status read. A broken same-cycle merge shows up as a lost bit on the read that follows. Any status error is also visible on `irq_out`/`irq_oe` in the same cycle, so every cycle of the random run compares both the read data and the interrupt pins.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NSRC   = 3;

  // Bit positions of the sources inside every per-source register.
  localparam logic [DATA_W-1:0] LIVE_BITS = 8'b0000_1011;
  localparam logic [DATA_W-1:0] CTRL_BITS = 8'b0000_0001;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODEH  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODEL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_NONE  = 2'b11
  } trig_mode_e;

  // Source index 0 = underflow, 1 = overflow, 2 = clock error.
  function automatic int unsigned src_pos(input int unsigned idx);
    return (idx == 2) ? 3 : idx;
  endfunction
endpackage

// File: rtl/evt_trigger.sv
module evt_trigger
  import evt_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_i,
  input  trig_mode_e mode_i,
  output logic       hit_o
);
  logic evt_q, evt_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      evt_p <= 1'b0;
    end else begin
      evt_q <= evt_i;
      evt_p <= evt_q;
    end
  end

  always_comb begin
    unique case (mode_i)
      TRIG_RISE:  hit_o = evt_q & ~evt_p;
      TRIG_FALL:  hit_o = ~evt_q & evt_p;
      TRIG_LEVEL: hit_o = evt_q;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] mode_hi_o,
  output logic [DATA_W-1:0] mode_lo_o,
  output logic [DATA_W-1:0] ctrl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o    <= '0;
      mode_hi_o <= '0;
      mode_lo_o <= '0;
      ctrl_o    <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_MASK:  mask_o    <= wdata_i & LIVE_BITS;
        A_MODEH: mode_hi_o <= wdata_i & LIVE_BITS;
        A_MODEL: mode_lo_o <= wdata_i & LIVE_BITS;
        A_CTRL:  ctrl_o    <= wdata_i & CTRL_BITS;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evt_irq_drive.sv
module evt_irq_drive (
  input  logic active_i,
  input  logic push_pull_i,
  output logic out_o,
  output logic oe_o
);
  // Push-pull: always driven, value follows activity.
  // Open drain: pull low when active, otherwise release.
  assign out_o = push_pull_i & active_i;
  assign oe_o  = push_pull_i | active_i;
endmodule

// File: rtl/evt_status_irq.sv
module evt_status_irq
  import evt_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_err_evt,
  input  logic              ovfl_evt,
  input  logic              undfl_evt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out,
  output logic              irq_oe
);
  logic [DATA_W-1:0] mask_q, mode_hi_q, mode_lo_q, ctrl_q;
  logic [DATA_W-1:0] status_q, hit_vec, visible;
  logic [NSRC-1:0]   src_evt, src_hit;
  logic              rd_clear;

  assign src_evt = {clk_err_evt, ovfl_evt, undfl_evt};

  evt_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr),
    .addr_i    (reg_addr),
    .wdata_i   (reg_wdata),
    .mask_o    (mask_q),
    .mode_hi_o (mode_hi_q),
    .mode_lo_o (mode_lo_q),
    .ctrl_o    (ctrl_q)
  );

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    localparam int unsigned POS = src_pos(gi);
    trig_mode_e mode;
    assign mode = trig_mode_e'({mode_hi_q[POS], mode_lo_q[POS]});
    evt_trigger u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (src_evt[gi]),
      .mode_i (mode),
      .hit_o  (src_hit[gi])
    );
  end

  always_comb begin
    hit_vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      hit_vec[src_pos(i)] = src_hit[i];
    end
    hit_vec = hit_vec & mask_q;
  end

  assign rd_clear = reg_rd && (reg_addr == A_STATUS);
  assign visible  = status_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= ((rd_clear ? '0 : status_q) | hit_vec) & mask_q;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_STATUS: reg_rdata = visible;
      A_MASK:   reg_rdata = mask_q;
      A_MODEH:  reg_rdata = mode_hi_q;
      A_MODEL:  reg_rdata = mode_lo_q;
      A_CTRL:   reg_rdata = ctrl_q;
      default:  reg_rdata = '0;
    endcase
  end

  evt_irq_drive u_irq (
    .active_i    (|visible),
    .push_pull_i (ctrl_q[0]),
    .out_o       (irq_out),
    .oe_o        (irq_oe)
  );
endmodule

// File: rtl/evt_status_irq_chk.sv
module evt_status_irq_chk
  import evt_status_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] hit_vec,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] mode_hi_q,
  input logic [DATA_W-1:0] mode_lo_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              irq_out,
  input logic              irq_oe
);
  // R2: only the three source positions may ever hold a status bit
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~LIVE_BITS) == '0);

  // R6: a disabled source's bit is clear one edge after the mask says so
  assert_masked_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q & ~$past(mask_q)) == '0);

  // R4: a status read with no simultaneous trigger leaves nothing set
  assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_STATUS && hit_vec == '0) |=> status_q == '0);

  // R3: without a status read, set and still-enabled bits remain set
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == A_STATUS)
      |=> (($past(status_q) & $past(mask_q)) & ~status_q) == '0);

  // R10: reserved mode never raises a bit
  assert_rsvd_mode_undfl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[0]) |-> !($past(mode_hi_q[0]) && $past(mode_lo_q[0])));
  assert_rsvd_mode_ovfl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[1]) |-> !($past(mode_hi_q[1]) && $past(mode_lo_q[1])));
  assert_rsvd_mode_clkerr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[3]) |-> !($past(mode_hi_q[3]) && $past(mode_lo_q[3])));

  // R11: push-pull drive is always enabled and high only with pending status
  assert_irq_push_pull_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] |-> (irq_oe && (irq_out == ((status_q & mask_q) != '0))));

  // R12: open-drain never drives high; enable tracks pending status
  assert_irq_open_drain_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> (!irq_out && (irq_oe == ((status_q & mask_q) != '0))));
endmodule

bind evt_status_irq evt_status_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .status_q  (status_q),
  .hit_vec   (hit_vec),
  .mask_q    (mask_q),
  .mode_hi_q (mode_hi_q),
  .mode_lo_q (mode_lo_q),
  .ctrl_q    (ctrl_q),
  .irq_out   (irq_out),
  .irq_oe    (irq_oe)
);

// File: tb/evt_status_irq_bench.sv
`timescale 1ns/1ps
module evt_status_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_err_evt = 1'b0, ovfl_evt = 1'b0, undfl_evt = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_out, irq_oe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_status_irq u_evt_status_irq (
    .clk (clk), .rst_n (rst_n),
    .clk_err_evt (clk_err_evt), .ovfl_evt (ovfl_evt), .undfl_evt (undfl_evt),
    .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .irq_out (irq_out), .irq_oe (irq_oe)
  );

  // Reference model built from the requirements.
  logic [7:0] m_stat, m_mask, m_hi, m_lo, m_ctrl;
  logic [2:0] m_q, m_p;

  function automatic int unsigned pos_of(input int i);
    return (i == 2) ? 3 : i;
  endfunction

  function automatic logic [7:0] model_hits();
    logic [7:0] h = '0;
    for (int i = 0; i < 3; i++) begin
      int unsigned b = pos_of(i);
      logic [1:0] md = {m_hi[b], m_lo[b]};
      case (md)
        2'b00: h[b] = m_q[i] & ~m_p[i];
        2'b01: h[b] = ~m_q[i] & m_p[i];
        2'b10: h[b] = m_q[i];
        default: h[b] = 1'b0;
      endcase
    end
    return h & m_mask;
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [2:0] a);
    case (a)
      3'd0: return m_stat & m_mask;
      3'd1: return m_mask;
      3'd2: return m_hi;
      3'd3: return m_lo;
      3'd4: return m_ctrl;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= '0; m_mask <= '0; m_hi <= '0; m_lo <= '0; m_ctrl <= '0;
      m_q <= '0; m_p <= '0;
    end else begin
      m_stat <= (((reg_rd && reg_addr == 3'd0) ? 8'h00 : m_stat) | model_hits()) & m_mask;
      m_p <= m_q;
      m_q <= {clk_err_evt, ovfl_evt, undfl_evt};
      if (reg_wr) begin
        case (reg_addr)
          3'd1: m_mask <= reg_wdata & 8'h0B;
          3'd2: m_hi   <= reg_wdata & 8'h0B;
          3'd3: m_lo   <= reg_wdata & 8'h0B;
          3'd4: m_ctrl <= reg_wdata & 8'h01;
          default: ;
        endcase
      end
    end
  end

  task automatic check_now(input string tag);
    logic [7:0] er = exp_rdata(reg_addr);
    logic act = (m_stat & m_mask) != 8'h00;
    logic eo = m_ctrl[0] & act;
    logic ee = m_ctrl[0] | act;
    checks++;
    if (reg_rdata !== er) begin
      errors++;
      $display("FAIL %s rdata addr=%0d actual=%02h expected=%02h", tag, reg_addr, reg_rdata, er);
    end
    checks++;
    if (irq_out !== eo || irq_oe !== ee) begin
      errors++;
      $display("FAIL %s irq actual out=%0b oe=%0b expected out=%0b oe=%0b",
               tag, irq_out, irq_oe, eo, ee);
    end
  endtask

  // One cycle: drive after the falling edge, check mid-cycle.
  task automatic step(input logic rd, input logic [2:0] a, input logic wr,
                      input logic [7:0] wd, input logic [2:0] ev, input string tag);
    @(negedge clk);
    reg_rd = rd; reg_addr = a; reg_wr = wr; reg_wdata = wd;
    {clk_err_evt, ovfl_evt, undfl_evt} = ev;
    #1;
    check_now(tag);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input logic [2:0] ev);
    step(1'b0, a, 1'b1, d, ev, "R2");
  endtask

  task automatic hard_check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check_now("R1");
    hard_check("R1", reg_rdata, 8'h00);
    hard_check("R1", {6'b0, irq_out, irq_oe}, 8'h00);
    rst_n = 1'b1;

    // Reserved bits and unused address
    step(1'b1, 3'd6, 1'b0, 8'h00, 3'b000, "R2");
    hard_check("R2", reg_rdata, 8'h00);

    // Enable all, push-pull, rising mode
    wr_reg(3'd1, 8'hFF, 3'b000);
    wr_reg(3'd4, 8'hFF, 3'b000);
    step(1'b1, 3'd1, 1'b0, 8'h00, 3'b000, "R2");
    hard_check("R2", reg_rdata, 8'h0B);

    // R7: overflow rising edge; set two edges after the line rises
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b010, "R7");
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b010, "R7");
    hard_check("R7", reg_rdata, 8'h00);
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b010, "R7");
    hard_check("R7", reg_rdata, 8'h02);
    // R3: stays set while line holds and after it drops (no fall in rising mode)
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b000, "R3");
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b000, "R3");
    step(1'b1, 3'd0, 1'b0, 8'h00, 3'b000, "R3");
    hard_check("R3", reg_rdata, 8'h02);
    // R4: cleared after the read
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b000, "R4");
    hard_check("R4", reg_rdata, 8'h00);

    // R8: falling mode on clock error (bit 3)
    wr_reg(3'd3, 8'h08, 3'b100);
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b100, "R8");
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b100, "R8");
    hard_check("R8", reg_rdata, 8'h00);
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b000, "R8");
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b000, "R8");
    step(1'b1, 3'd0, 1'b0, 8'h00, 3'b000, "R8");
    hard_check("R8", reg_rdata, 8'h08);
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b000, "R4");

    // R9 / R5: level mode on underflow; read while line high keeps bit set
    wr_reg(3'd2, 8'h01, 3'b001);
    wr_reg(3'd3, 8'h00, 3'b001);
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b001, "R9");
    step(1'b1, 3'd0, 1'b0, 8'h00, 3'b001, "R9");
    hard_check("R9", reg_rdata, 8'h01);
    step(1'b1, 3'd0, 1'b0, 8'h00, 3'b000, "R5");
    hard_check("R5", reg_rdata, 8'h01);
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b000, "R5");
    hard_check("R5", reg_rdata, 8'h01);
    step(1'b1, 3'd0, 1'b0, 8'h00, 3'b000, "R4");
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b000, "R4");
    hard_check("R4", reg_rdata, 8'h00);

    // R10: reserved mode on all sources
    wr_reg(3'd2, 8'hFF, 3'b000);
    wr_reg(3'd3, 8'hFF, 3'b111);
    for (int k = 0; k < 6; k++) step(1'b0, 3'd0, 1'b0, 8'h00, 3'(k[0] ? 7 : 0), "R10");
    hard_check("R10", reg_rdata, 8'h00);

    // R6: level mode but disabled sources
    wr_reg(3'd3, 8'h00, 3'b111);
    wr_reg(3'd1, 8'h00, 3'b111);
    for (int k = 0; k < 4; k++) step(1'b0, 3'd0, 1'b0, 8'h00, 3'b111, "R6");
    hard_check("R6", reg_rdata, 8'h00);

    // R12 / R11: open-drain drive with pending status, then push-pull
    wr_reg(3'd4, 8'h00, 3'b111);
    wr_reg(3'd1, 8'h02, 3'b111);
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b111, "R12");
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b111, "R12");
    hard_check("R12", {6'b0, irq_out, irq_oe}, 8'h01);
    wr_reg(3'd4, 8'h01, 3'b111);
    step(1'b0, 3'd0, 1'b0, 8'h00, 3'b111, "R11");
    hard_check("R11", {6'b0, irq_out, irq_oe}, 8'h03);

    // Random run against the model
    for (int n = 0; n < 4000; n++) begin
      logic rd = ($urandom_range(99) < 30);
      logic wr = ($urandom_range(99) < 5);
      logic [2:0] a = wr ? 3'($urandom_range(4, 1))
                         : (($urandom_range(3) == 0) ? 3'($urandom_range(6)) : 3'd0);
      logic [7:0] wd = 8'($urandom());
      logic [2:0] ev = {clk_err_evt, ovfl_evt, undfl_evt};
      for (int j = 0; j < 3; j++) if ($urandom_range(3) == 0) ev[j] = ~ev[j];
      step(rd, a, wr, wd, ev, "R3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule